// File: doc/BRIEF.md
# Two-Core Outbound Bus Arbiter

This block lets two requesting cores share one outgoing packet bus. Each core hands over packet beats through a valid/ready handshake. The beats go into a small queue for that core. A grant stage then moves one beat per cycle from a single queue onto a registered output stream, and it tags each beat with the core it came from. A packet is any run of beats that ends with a beat whose last flag is set. Once a packet has started, no beat from the other core can reach the output until that packet is finished.

The choice between cores alternates in round-robin order. A core that collects enough retries in a row is favoured for its next grant. The start of a new packet on the shared output is held back until a programmable spacing has passed since the previous start. The block also takes one snoop response from each core and produces one merged response: the most severe of the two, issued only after both have arrived.

Top module: `bus_share_arb`

## Requirements
- R1: After reset, out_valid and snp_out_valid are 0 and req_ready is 2'b11.
- R2: A beat that is accepted (req_valid and req_ready high at a rising edge) and can be granted at once shows up on out_data after the following rising edge. Its data and last flag are unchanged. out_src names the core (0 or 1). Beats from one core leave in the order they were accepted.
- R3: When both cores have a packet waiting at a decision, the core that was not granted most recently wins. After reset, core 0 is preferred.
- R4: After the first beat of a packet with out_last=0, every out beat comes from the same core until a beat with out_last=1 has been sent.
- R5: The first beats of two consecutive packets on out are at least P cycles apart, and exactly P apart when the next packet is already waiting. P is cfg_pace clamped to the range 2..14.
- R6: Each core has a retry count. It goes up by one on each retry_in pulse and saturates at its maximum. It clears on ack_in, and ack_in wins when both arrive in the same cycle. A core wins the next decision over round-robin when cfg_retry_thr is nonzero and its count is at least cfg_retry_thr. A value of 0 for cfg_retry_thr disables this favouring.
- R7: Each core's queue holds 4 beats. req_ready for a core is 0 while its queue is full and returns to 1 once the queue drains.
- R8: Snoop codes are 0 = null, 1 = shared, 2 = modified, 3 = retry. The merged snp_out_resp is the larger of the two codes.
- R9: snp_out_valid pulses for one cycle, after the rising edge at which the second of the two responses is captured. It stays 0 while only one response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 2 | Beat offered, one bit per core |
| req_data | input | 2 x DATA_W | Beat payload per core |
| req_last | input | 2 | Beat closes its packet, per core |
| req_ready | output | 2 | Queue can take a beat, per core |
| retry_in | input | 2 | Retry received, per core |
| ack_in | input | 2 | Transaction accepted, per core |
| cfg_pace | input | PACE_W | Minimum start-to-start packet spacing |
| cfg_retry_thr | input | RTY_W | Retry count that earns priority (0 = off) |
| snp_valid | input | 2 | Snoop response present, per core |
| snp_resp | input | 2 x 2 | Snoop response code per core |
| out_valid | output | 1 | Shared bus beat valid |
| out_data | output | DATA_W | Shared bus beat payload |
| out_last | output | 1 | Shared bus beat closes its packet |
| out_src | output | 1 | Core that owns the beat |
| snp_out_valid | output | 1 | Merged snoop response valid |
| snp_out_resp | output | 2 | Merged snoop response code |

## Verification
The pacing property assumes that cfg_pace does not change while packets are flowing. The bench changes it only after at least twenty idle cycles. The merge property assumes that each core sends at most one snoop response per merge. The bench always waits for the merged pulse before it sends the next pair. The queue properties assume that a core keeps req_valid and its beat steady until the beat is accepted, which is how the bench's push task drives them.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
    localparam int unsigned NREQ = 2;

    typedef enum logic [1:0] {
        SNP_NULL   = 2'd0,
        SNP_SHARED = 2'd1,
        SNP_MOD    = 2'd2,
        SNP_RETRY  = 2'd3
    } snp_e;

    // severity follows the numeric code, so the worse response is the larger one
    function automatic logic [1:0] snp_worse(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/busarb_fifo.sv
module busarb_fifo #(
    parameter int unsigned WIDTH = 17,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic             full,
    output logic             empty,
    output logic [WIDTH-1:0] rd_data
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        if (rd_en) s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        s_d.cnt = s_q.cnt + CW'(wr_en) - CW'(rd_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[s_q.wp] <= wr_data;
    end

    assign full    = (s_q.cnt == CW'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign rd_data = mem_q[s_q.rp];
endmodule

// File: rtl/busarb_pick.sv
module busarb_pick (
    input  logic [1:0] pend,
    input  logic [1:0] boost,
    input  logic       last,
    output logic       gv,
    output logic       gid
);
    logic [1:0] hot;

    always_comb begin
        hot = pend & boost;
        gv  = |pend;
        if (hot == 2'b01)       gid = 1'b0;
        else if (hot == 2'b10)  gid = 1'b1;
        else if (pend == 2'b01) gid = 1'b0;
        else if (pend == 2'b10) gid = 1'b1;
        else                    gid = ~last;
    end
endmodule

// File: rtl/busarb_snoop.sv
module busarb_snoop
    import busarb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      in_v,
    input  logic [1:0][1:0] in_r,
    output logic            out_v,
    output logic [1:0]      out_r
);
    typedef struct packed {
        logic [1:0]      have;
        logic [1:0][1:0] resp;
        logic            ov;
        logic [1:0]      orsp;
    } sst_t;

    sst_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ov = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (in_v[i]) begin
                s_d.have[i] = 1'b1;
                s_d.resp[i] = in_r[i];
            end
        end
        if (&s_d.have) begin
            s_d.ov   = 1'b1;
            s_d.orsp = snp_worse(s_d.resp[0], s_d.resp[1]);
            s_d.have = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_v = s_q.ov;
    assign out_r = s_q.orsp;
endmodule

// File: rtl/bus_share_arb.sv
module bus_share_arb
    import busarb_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned QDEPTH   = 4,
    parameter int unsigned RTY_W    = 3,
    parameter int unsigned PACE_W   = 4,
    parameter int unsigned PACE_MIN = 2,
    parameter int unsigned PACE_MAX = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             req_valid,
    input  logic [1:0][DATA_W-1:0] req_data,
    input  logic [1:0]             req_last,
    output logic [1:0]             req_ready,
    input  logic [1:0]             retry_in,
    input  logic [1:0]             ack_in,
    input  logic [PACE_W-1:0]      cfg_pace,
    input  logic [RTY_W-1:0]       cfg_retry_thr,
    input  logic [1:0]             snp_valid,
    input  logic [1:0][1:0]        snp_resp,
    output logic                   out_valid,
    output logic [DATA_W-1:0]      out_data,
    output logic                   out_last,
    output logic                   out_src,
    output logic                   snp_out_valid,
    output logic [1:0]             snp_out_resp
);
    localparam int unsigned FW = DATA_W + 1;
    localparam logic [RTY_W-1:0] RCNT_MAX = '1;

    typedef struct packed {
        logic [1:0][RTY_W-1:0] rcnt;
        logic                  busy;
        logic                  own;
        logic                  last;
        logic [PACE_W-1:0]     gap;
        logic                  ov;
        logic [DATA_W-1:0]     od;
        logic                  ol;
        logic                  osrc;
    } st_t;

    st_t s_d, s_q;

    logic [1:0]          f_full, f_empty, f_push, f_pop;
    logic [1:0][FW-1:0]  f_head;
    logic [1:0]          boost;
    logic                gv, gid;
    logic [PACE_W-1:0]   pace_eff;
    logic                sel, take;

    assign f_push    = req_valid & ~f_full;
    assign req_ready = ~f_full;

    for (genvar g = 0; g < NREQ; g++) begin : g_q
        busarb_fifo #(.WIDTH(FW), .DEPTH(QDEPTH)) i_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (f_push[g]),
            .wr_data ({req_last[g], req_data[g]}),
            .rd_en   (f_pop[g]),
            .full    (f_full[g]),
            .empty   (f_empty[g]),
            .rd_data (f_head[g])
        );
        assign boost[g] = (cfg_retry_thr != '0) && (s_q.rcnt[g] >= cfg_retry_thr);
    end

    busarb_pick i_pick (
        .pend  (~f_empty),
        .boost (boost),
        .last  (s_q.last),
        .gv    (gv),
        .gid   (gid)
    );

    busarb_snoop i_snoop (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (snp_valid),
        .in_r  (snp_resp),
        .out_v (snp_out_valid),
        .out_r (snp_out_resp)
    );

    always_comb begin
        if (cfg_pace < PACE_W'(PACE_MIN))      pace_eff = PACE_W'(PACE_MIN);
        else if (cfg_pace > PACE_W'(PACE_MAX)) pace_eff = PACE_W'(PACE_MAX);
        else                                   pace_eff = cfg_pace;
    end

    always_comb begin
        s_d    = s_q;
        s_d.ov = 1'b0;
        f_pop  = '0;
        sel    = s_q.own;
        take   = 1'b0;
        s_d.gap = (s_q.gap != '0) ? s_q.gap - 1'b1 : '0;

        if (s_q.busy) begin
            sel  = s_q.own;
            take = ~f_empty[s_q.own];
        end else if (s_q.gap == '0 && gv) begin
            sel      = gid;
            take     = 1'b1;
            s_d.gap  = pace_eff - 1'b1;
            s_d.last = gid;
            s_d.own  = gid;
        end

        if (take) begin
            f_pop[sel] = 1'b1;
            s_d.ov     = 1'b1;
            s_d.od     = f_head[sel][DATA_W-1:0];
            s_d.ol     = f_head[sel][DATA_W];
            s_d.osrc   = sel;
            s_d.busy   = ~f_head[sel][DATA_W];
        end

        for (int i = 0; i < NREQ; i++) begin
            if (ack_in[i])
                s_d.rcnt[i] = '0;
            else if (retry_in[i] && s_q.rcnt[i] != RCNT_MAX)
                s_d.rcnt[i] = s_q.rcnt[i] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.last <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.ov;
    assign out_data  = s_q.od;
    assign out_last  = s_q.ol;
    assign out_src   = s_q.osrc;
endmodule

// File: rtl/busarb_chk.sv
module busarb_chk #(
    parameter int unsigned PACE_W   = 4,
    parameter int unsigned PACE_MIN = 2,
    parameter int unsigned PACE_MAX = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        req_valid,
    input logic [1:0]        req_ready,
    input logic              out_valid,
    input logic              out_last,
    input logic              out_src,
    input logic [PACE_W-1:0] cfg_pace,
    input logic [1:0]        snp_valid,
    input logic              snp_out_valid
);
    logic            busy_c, src_c, started_c;
    logic [1:0][7:0] pend_c;
    logic [4:0]      since_c;
    logic [1:0]      seen_c;
    logic [4:0]      pace_c;

    always_comb begin
        if (cfg_pace < PACE_W'(PACE_MIN))      pace_c = 5'(PACE_MIN);
        else if (cfg_pace > PACE_W'(PACE_MAX)) pace_c = 5'(PACE_MAX);
        else                                   pace_c = 5'(cfg_pace);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_c    <= 1'b0;
            src_c     <= 1'b0;
            started_c <= 1'b0;
            pend_c    <= '0;
            since_c   <= '0;
            seen_c    <= '0;
        end else begin
            for (int i = 0; i < 2; i++)
                pend_c[i] <= pend_c[i] + 8'(req_valid[i] & req_ready[i])
                                       - 8'(out_valid && (out_src == 1'(i)));
            if (out_valid) begin
                busy_c <= ~out_last;
                src_c  <= out_src;
            end
            if (out_valid && !busy_c) begin
                since_c   <= 5'd1;
                started_c <= 1'b1;
            end else if (since_c != 5'd31) begin
                since_c <= since_c + 5'd1;
            end
            seen_c <= snp_out_valid ? snp_valid : (seen_c | snp_valid);
        end
    end

    p_no_phantom_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pend_c[out_src] != 8'd0));

    p_hold_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && busy_c) |-> (out_src == src_c));

    p_pace_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !busy_c && started_c) |-> (since_c >= pace_c));

    p_merge_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_out_valid |-> (seen_c == 2'b11));
endmodule

bind bus_share_arb busarb_chk #(
    .PACE_W   (PACE_W),
    .PACE_MIN (PACE_MIN),
    .PACE_MAX (PACE_MAX)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .out_valid     (out_valid),
    .out_last      (out_last),
    .out_src       (out_src),
    .cfg_pace      (cfg_pace),
    .snp_valid     (snp_valid),
    .snp_out_valid (snp_out_valid)
);

// File: tb/test_bus_share_arb.sv
module test_bus_share_arb;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [1:0]         v = '0, lt = '0, rty = '0, ack = '0, sv = '0;
    logic [1:0][DW-1:0] rd = '0;
    logic [1:0][1:0]    sr = '0;
    logic [3:0]         pace = 4'd2;
    logic [2:0]         thr = 3'd0;

    logic [1:0]    req_ready;
    logic          out_valid, out_last, out_src, snp_out_valid;
    logic [DW-1:0] out_data;
    logic [1:0]    snp_out_resp;

    bus_share_arb #(.DATA_W(DW), .QDEPTH(4), .RTY_W(3), .PACE_W(4)) i_bus_share_arb (
        .clk(clk), .rst_n(rst_n),
        .req_valid(v), .req_data(rd), .req_last(lt), .req_ready(req_ready),
        .retry_in(rty), .ack_in(ack),
        .cfg_pace(pace), .cfg_retry_thr(thr),
        .snp_valid(sv), .snp_resp(sr),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_src(out_src),
        .snp_out_valid(snp_out_valid), .snp_out_resp(snp_out_resp)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int          n_out = 0;
    logic        lsrc  [64];
    logic [15:0] ldat  [64];
    logic        llast [64];
    int          lcyc  [64];

    always @(negedge clk) begin
        if (rst_n && out_valid && n_out < 64) begin
            lsrc[n_out]  = out_src;
            ldat[n_out]  = out_data;
            llast[n_out] = out_last;
            lcyc[n_out]  = cyc;
            n_out = n_out + 1;
        end
    end

    int errs = 0, checks = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int c, input logic [15:0] d, input logic l, output int acc);
        @(posedge clk); #1;
        v[c] = 1'b1; rd[c] = d; lt[c] = l;
        @(negedge clk);
        while (!req_ready[c]) @(negedge clk);
        acc = cyc;
        @(posedge clk); #1;
        v[c] = 1'b0;
    endtask

    task automatic push_pkt(input int c, input int nb, input logic [15:0] base);
        int a;
        for (int k = 0; k < nb; k++) push(c, base + 16'(k), (k == nb - 1), a);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input int c, input bit r, input bit a);
        @(posedge clk); #1;
        rty[c] = r; ack[c] = a;
        @(posedge clk); #1;
        rty[c] = 1'b0; ack[c] = 1'b0;
    endtask

    task automatic round(input bit d0, input bit d1, input int exp_first, input string tag);
        int a0, a1;
        n_out = 0;
        fork
            if (d0) push(0, 16'h0A00, 1'b1, a0);
            if (d1) push(1, 16'h0B00, 1'b1, a1);
        join
        idle(10);
        chk({tag, " beat count"}, n_out, int'(d0) + int'(d1));
        chk({tag, " first grant"}, int'(lsrc[0]), exp_first);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int a, clampv, s;
        logic [15:0] e;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 snp_out_valid", int'(snp_out_valid), 0);
        chk("R1 req_ready", int'(req_ready), 3);

        // R2 latency and passthrough
        n_out = 0;
        push(0, 16'h1234, 1'b1, a);
        idle(4);
        chk("R2 count", n_out, 1);
        chk("R2 latency", lcyc[0] - a, 2);
        chk("R2 data", int'(ldat[0]), 16'h1234);
        chk("R2 last", int'(llast[0]), 1);
        chk("R2 src", int'(lsrc[0]), 0);
        idle(10);

        // R3 round-robin over several arrival patterns (last granted now core 0)
        round(1, 1, 1, "R3 both after core0");
        round(0, 1, 1, "R3 core1 alone");
        round(1, 1, 0, "R3 both after core1");
        round(1, 0, 0, "R3 core0 alone");
        round(1, 1, 1, "R3 both again");

        // R6 retry favouring (last granted is core 0 here)
        thr = 3'd2;
        pulse(0, 1, 0);
        pulse(0, 1, 0);
        round(1, 1, 0, "R6 boosted core0");
        pulse(0, 0, 1);
        pulse(1, 1, 0);
        round(1, 1, 0, "R6 below threshold");
        pulse(1, 1, 0);
        round(1, 1, 1, "R6 boosted core1");
        round(0, 1, 1, "R6 setup");
        thr = 3'd0;
        round(1, 1, 0, "R6 threshold zero off");
        thr = 3'd2;
        round(0, 1, 1, "R6 setup2");
        round(1, 1, 1, "R6 boost re-enabled");
        pulse(1, 1, 1);
        round(0, 1, 1, "R6 setup3");
        thr = 3'd1;
        round(1, 1, 0, "R6 ack beats retry");
        thr = 3'd0;
        idle(20);

        // R4 multi-beat packets are never interleaved
        n_out = 0;
        fork
            push_pkt(0, 3, 16'h0100);
            push_pkt(1, 3, 16'h0200);
        join
        idle(20);
        chk("R4 count", n_out, 6);
        s = int'(lsrc[0]);
        for (int k = 0; k < 6; k++) begin
            int src_e;
            src_e = (k < 3) ? s : 1 - s;
            e = (src_e == 0 ? 16'h0100 : 16'h0200) + 16'(k % 3);
            chk("R4 src", int'(lsrc[k]), src_e);
            chk("R4 data", int'(ldat[k]), int'(e));
            chk("R4 last", int'(llast[k]), (k % 3 == 2) ? 1 : 0);
        end

        // R5 pacing sweep over every setting
        for (int p = 0; p < 16; p++) begin
            pace = 4'(p);
            idle(20);
            n_out = 0;
            push(0, 16'h0C00, 1'b1, a);
            push(0, 16'h0C01, 1'b1, a);
            idle(20);
            clampv = (p < 2) ? 2 : ((p > 14) ? 14 : p);
            chk($sformatf("R5 count pace=%0d", p), n_out, 2);
            chk($sformatf("R5 spacing pace=%0d", p), lcyc[1] - lcyc[0], clampv);
        end

        // R7 queue fills while the pacing window blocks a start
        pace = 4'd14;
        idle(20);
        n_out = 0;
        push(1, 16'h0300, 1'b1, a);
        for (int k = 0; k < 4; k++) push(0, 16'h0400 + 16'(k), 1'b0, a);
        @(negedge clk);
        chk("R7 ready low when full", int'(req_ready[0]), 0);
        chk("R7 other core ready", int'(req_ready[1]), 1);
        push(0, 16'h0404, 1'b1, a);
        idle(40);
        chk("R7 ready restored", int'(req_ready[0]), 1);
        chk("R7 count", n_out, 6);
        chk("R7 first src", int'(lsrc[0]), 1);
        for (int k = 1; k < 6; k++) begin
            chk("R7 src", int'(lsrc[k]), 0);
            chk("R7 order", int'(ldat[k]), 16'h0400 + k - 1);
        end
        chk("R5 spacing at max", lcyc[1] - lcyc[0], 14);
        pace = 4'd2;
        idle(20);

        // R8/R9 snoop merge, all code pairs arriving together
        for (int x = 0; x < 4; x++) begin
            for (int y = 0; y < 4; y++) begin
                @(posedge clk); #1;
                sv = 2'b11; sr[0] = 2'(x); sr[1] = 2'(y);
                @(negedge clk);
                chk("R9 not before capture", int'(snp_out_valid), 0);
                @(posedge clk); #1;
                sv = 2'b00;
                chk("R9 valid after capture", int'(snp_out_valid), 1);
                chk($sformatf("R8 merge %0d,%0d", x, y), int'(snp_out_resp), (x > y) ? x : y);
                @(posedge clk); #1;
                chk("R9 single pulse", int'(snp_out_valid), 0);
            end
        end

        // R9 staggered arrival in both orders
        for (int o = 0; o < 2; o++) begin
            @(posedge clk); #1;
            sv[o] = 1'b1; sr[o] = (o == 0) ? 2'd3 : 2'd2;
            @(posedge clk); #1;
            sv = 2'b00;
            for (int w = 0; w < 3; w++) begin
                chk("R9 waits for both", int'(snp_out_valid), 0);
                @(posedge clk); #1;
            end
            sv[1-o] = 1'b1; sr[1-o] = 2'd0;
            @(posedge clk); #1;
            sv = 2'b00;
            chk("R9 staggered valid", int'(snp_out_valid), 1);
            chk("R8 staggered merge", int'(snp_out_resp), (o == 0) ? 3 : 2);
            @(posedge clk); #1;
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule